// File: doc/BRIEF.md
# Gapless Double-Buffered Serial Transmitter

This block sends a long serial bit stream, one bit for each bit-clock enable, with nothing inserted between words. Each word is written into a holding register over a valid/ready handshake. It moves into a separate shift register on the bit period that follows the last bit of the word before it. A producer that refills the holding register while a word is shifting therefore keeps the line continuous across tens of thousands of bits.

A stream begins when the enable is high and the holding register is full. A frame-sync pulse one bit period long marks the start. The first data bit follows it after a programmable delay of zero to three bit periods. With a delay of zero, the first bit goes out together with the sync. Per-word sync mode adds a further pulse for every later word. A stream counter, loaded with the total bit count at start, ends the stream after exactly that many data bits. The line then returns low and a done flag rises. If the holding register is empty at a word boundary, an underrun flag is raised and the line holds its last bit until data arrives. No bit is lost.

Top module: `gapless_serial_tx`

## Requirements
- R1: Data leaves MSB first on `sdata`, one bit for each `bit_en` tick. When the next word is in the holding register before the boundary, the LSB of one word is followed on the very next tick by the MSB of the next word.
- R2: `wr_ready` is high exactly when the holding register is empty. A write is taken on a clock edge with `wr_valid` and `wr_ready` both high. `wr_ready` rises only on the tick that moves the held word into the shift register.
- R3: The stream starts on the first tick with `en` high and the holding register full. That tick drives `fsync` high for one bit period. With `sync_delay` = d (0 to 3), data bit 0 appears d ticks after the start tick, so it shares the sync tick when d = 0. `sdata` is low during the delay ticks.
- R4: With `per_word_sync` = 1, counting the start tick as t = 0, `fsync` is also high on each tick t = 32k (k >= 1) for which data bit index t - d is below the total bit count.
- R5: With `per_word_sync` = 0, `fsync` is high only on the start tick.
- R6: After exactly `total_bits` data bits (`total_bits` >= 1), `sdata` goes low and `done` goes high on tick d + `total_bits`. Both hold while `en` stays high.
- R7: At a word boundary with the holding register empty, `underrun` is set and stays set. `sdata` holds the last bit sent. On the first tick after the next write, that word's MSB goes out and the count continues, so no data bit is dropped.
- R8: With `en` low, one clock edge sets `sdata`, `fsync`, `done` and `underrun` to 0 and returns the block to waiting for a start. The holding register and `wr_ready` are not touched.
- R9: The outputs `sdata` and `fsync` change only on clock edges where `bit_en` is high, or where `en` is low.
- R10: After reset, `wr_ready` = 1 and `sdata`, `fsync`, `done` and `underrun` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Stream enable; low returns to idle |
| bit_en | input | 1 | Bit-clock enable, one tick per bit period |
| sync_delay | input | 2 | Bit periods from sync to first data bit |
| per_word_sync | input | 1 | 1: a sync pulse for every word |
| total_bits | input | CNT_W | Data bits in the stream, latched at start |
| wr_valid | input | 1 | Write request for the holding register |
| wr_data | input | WORD_W | Word to hold |
| wr_ready | output | 1 | Holding register empty |
| fsync | output | 1 | Frame-sync pulse |
| sdata | output | 1 | Serial data line |
| underrun | output | 1 | Sticky: a boundary found no data |
| done | output | 1 | Stream count reached |

## Verification
The bench compares whole streams tick by tick for every sync delay, in both sync modes, and with bit counts that end both inside a word and on a word boundary. A reload that is one tick late would insert a repeated bit at every boundary. A delay counter off by one would shift every bit. A stream counter that miscounts would end the line a bit early or late, or raise a false underrun at the end. The bench also starves the holding register in mid-stream. A design that carried on shifting zeros, or that dropped the first bit of the late word, would fail the comparison of the held bit and the comparison of the next 32 bits. Finally, the bench drops the enable with a word still held. A design that cleared the holding register at that point would show `wr_ready` high.

// File: rtl/gapless_serial_tx.sv
module gapless_serial_tx #(
  parameter int WORD_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              bit_en,
  input  logic [1:0]        sync_delay,
  input  logic              per_word_sync,
  input  logic [CNT_W-1:0]  total_bits,
  input  logic              wr_valid,
  input  logic [WORD_W-1:0] wr_data,
  output logic              wr_ready,
  output logic              fsync,
  output logic              sdata,
  output logic              underrun,
  output logic              done
);
  localparam int POS_W = $clog2(WORD_W + 1);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(WORD_W);

  typedef enum logic [1:0] {S_IDLE, S_DELAY, S_SHIFT, S_FIN} st_t;

  st_t               st;
  logic [WORD_W-1:0] hold, shreg;
  logic              hold_full;
  logic [POS_W-1:0]  pos;
  logic [CNT_W-1:0]  remain;
  logic [1:0]        dcnt, dly_cfg;
  logic              pw_cfg;
  logic              take;

  assign wr_ready = !hold_full;

  assign take = bit_en && en && hold_full &&
                ((st == S_IDLE) ||
                 (st == S_SHIFT && remain != '0 && pos == LAST_POS));

  always_ff @(posedge clk) begin
    if (wr_valid && !hold_full) hold <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                    hold_full <= 1'b0;
    else if (wr_valid && !hold_full) hold_full <= 1'b1;
    else if (take)                 hold_full <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      shreg    <= '0;
      pos      <= '0;
      remain   <= '0;
      dcnt     <= '0;
      dly_cfg  <= '0;
      pw_cfg   <= 1'b0;
      sdata    <= 1'b0;
      fsync    <= 1'b0;
      done     <= 1'b0;
      underrun <= 1'b0;
    end else if (!en) begin
      st       <= S_IDLE;
      sdata    <= 1'b0;
      fsync    <= 1'b0;
      done     <= 1'b0;
      underrun <= 1'b0;
    end else if (bit_en) begin
      fsync <= 1'b0;
      case (st)
        S_IDLE: if (hold_full) begin
          dly_cfg <= sync_delay;
          pw_cfg  <= per_word_sync;
          fsync   <= 1'b1;
          if (sync_delay == 2'd0) begin
            sdata  <= hold[WORD_W-1];
            shreg  <= hold << 1;
            pos    <= POS_W'(1);
            remain <= total_bits - 1'b1;
            st     <= S_SHIFT;
          end else begin
            sdata  <= 1'b0;
            shreg  <= hold;
            remain <= total_bits;
            dcnt   <= sync_delay - 2'd1;
            st     <= S_DELAY;
          end
        end
        S_DELAY: if (dcnt == 2'd0) begin
          sdata  <= shreg[WORD_W-1];
          shreg  <= shreg << 1;
          pos    <= POS_W'(1);
          remain <= remain - 1'b1;
          st     <= S_SHIFT;
        end else begin
          dcnt <= dcnt - 2'd1;
        end
        S_SHIFT: if (remain == '0) begin
          sdata <= 1'b0;
          done  <= 1'b1;
          st    <= S_FIN;
        end else if (pos == LAST_POS) begin
          if (hold_full) begin
            sdata  <= hold[WORD_W-1];
            shreg  <= hold << 1;
            pos    <= POS_W'(1);
            remain <= remain - 1'b1;
            if (pw_cfg && dly_cfg == 2'd0) fsync <= 1'b1;
          end else begin
            underrun <= 1'b1;
          end
        end else begin
          sdata  <= shreg[WORD_W-1];
          shreg  <= shreg << 1;
          pos    <= pos + 1'b1;
          remain <= remain - 1'b1;
          if (pw_cfg && dly_cfg != 2'd0 && pos == LAST_POS - POS_W'(dly_cfg))
            fsync <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  assert_hold_between_ticks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_en && en) |=> ($stable(sdata) && $stable(fsync)));

  assert_ready_falls_on_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_ready) |-> $past(wr_valid));

  assert_ready_rises_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_ready) |-> $past(bit_en && en));

  assert_underrun_when_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(underrun) |-> $past(wr_ready && bit_en));

  assert_done_line_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!sdata && !fsync));

  assert_idle_when_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!sdata && !done && !underrun));
endmodule

// File: tb/gapless_serial_tx_tb.sv
module gapless_serial_tx_tb;
  localparam int W  = 32;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en = 1'b0;
  logic          bit_en = 1'b0;
  logic [1:0]    sync_delay = 2'd0;
  logic          per_word_sync = 1'b0;
  logic [CW-1:0] total_bits = '0;
  logic          wr_valid = 1'b0;
  logic [W-1:0]  wr_data = '0;
  logic          wr_ready, fsync, sdata, underrun, done;

  int total = 0;
  int bad = 0;
  int divc = 0;

  logic rs [0:1023];
  logic rf [0:1023];
  logic rd [0:1023];

  // {delay, per_word, total_bits, seed}
  localparam logic [46:0] VEC [6] = '{
    {2'd0, 1'b0, 12'd64,  32'hA5C3_0F1E},
    {2'd1, 1'b0, 12'd100, 32'h1234_5678},
    {2'd2, 1'b0, 12'd37,  32'hDEAD_BEEF},
    {2'd0, 1'b1, 12'd96,  32'h0F0F_3C3C},
    {2'd2, 1'b1, 12'd80,  32'h8001_7FFE},
    {2'd1, 1'b1, 12'd33,  32'h5555_AAAA}
  };

  gapless_serial_tx #(.WORD_W(W), .CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .bit_en(bit_en),
    .sync_delay(sync_delay), .per_word_sync(per_word_sync),
    .total_bits(total_bits), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_ready(wr_ready), .fsync(fsync), .sdata(sdata),
    .underrun(underrun), .done(done)
  );

  always #10 clk = ~clk;

  always @(negedge clk) begin
    divc   <= (divc + 1) % 4;
    bit_en <= (divc == 3);
  end

  initial begin
    #(20 * 150000);
    total++; bad++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  function automatic logic [W-1:0] wgen(input logic [31:0] seed, input int k);
    logic [31:0] kk = 32'(k);
    return seed ^ (kk * 32'h9E37_79B9) ^ {kk[15:0], 16'h00C3};
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic put_word(input logic [W-1:0] w);
    @(negedge clk);
    wr_data  = w;
    wr_valid = 1'b1;
    do @(posedge clk); while (!wr_ready);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic next_tick();
    do @(posedge clk); while (!bit_en);
    @(negedge clk);
  endtask

  task automatic run_vec(input logic [1:0] d, input logic pw, input int nb, input logic [31:0] seed);
    int ndw = (nb + 31) / 32;
    int n   = int'(d) + nb + 3;
    int ms = 0, mf = 0, md = 0;
    int fs_t = -1;
    sync_delay = d; per_word_sync = pw; total_bits = CW'(nb);
    put_word(wgen(seed, 0));
    @(negedge clk) en = 1'b1;
    fork
      begin
        for (int k = 1; k < ndw; k++) put_word(wgen(seed, k));
      end
      begin
        for (int t = 0; t < n; t++) begin
          next_tick();
          rs[t] = sdata; rf[t] = fsync; rd[t] = done;
        end
      end
    join
    for (int t = 0; t < n; t++) begin
      int i = t - int'(d);
      logic es, ef, ed;
      logic [W-1:0] w;
      w  = wgen(seed, (i < 0) ? 0 : i / 32);
      es = (i >= 0 && i < nb) ? w[31 - (i % 32)] : 1'b0;
      ef = (t == 0) || (pw && t > 0 && (t % 32) == 0 && i < nb);
      ed = (i >= nb);
      if (rs[t] !== es) begin ms++; end
      if (rf[t] !== ef) begin mf++; if (fs_t < 0) fs_t = t; end
      if (rd[t] !== ed) md++;
    end
    check(ms == 0, pw ? "R1 R3 stream data (per-word)" : "R1 R3 stream data", ms, 0);
    check(mf == 0, pw ? "R4 fsync per-word mismatches" : "R5 fsync single mismatches", mf, 0);
    check(md == 0, "R6 done timing mismatches", md, 0);
    check(underrun == 1'b0, "R6 no underrun at stream end", int'(underrun), 0);
    @(negedge clk) en = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    logic [W-1:0] w0, w1;
    int mm;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(wr_ready == 1'b1, "R10 reset wr_ready", int'(wr_ready), 1);
    check(sdata == 1'b0 && fsync == 1'b0, "R10 reset line and sync", int'({sdata, fsync}), 0);
    check(done == 1'b0 && underrun == 1'b0, "R10 reset flags", int'({done, underrun}), 0);

    for (int v = 0; v < 6; v++)
      run_vec(VEC[v][46:45], VEC[v][44], int'(VEC[v][43:32]), VEC[v][31:0]);

    w0 = 32'hC0DE_F00D;
    w1 = 32'h3B5A_9E61;
    sync_delay = 2'd0; per_word_sync = 1'b0; total_bits = CW'(64);
    put_word(w0);
    repeat (5) next_tick();
    check(wr_ready == 1'b0, "R8 held word kept while disabled", int'(wr_ready), 0);
    check(sdata == 1'b0 && fsync == 1'b0, "R9 no output while disabled", int'({sdata, fsync}), 0);

    @(negedge clk) en = 1'b1;
    next_tick();
    check(wr_ready == 1'b1, "R2 ready after reload tick", int'(wr_ready), 1);
    check(fsync == 1'b1, "R3 sync on start tick delay 0", int'(fsync), 1);
    mm = (sdata !== w0[31]) ? 1 : 0;
    for (int t = 1; t < 32; t++) begin
      next_tick();
      if (sdata !== w0[31 - t]) mm++;
    end
    check(mm == 0, "R1 first word before underrun", mm, 0);
    next_tick();
    check(underrun == 1'b1, "R7 underrun at empty boundary", int'(underrun), 1);
    check(sdata == w0[0], "R7 line holds last bit", int'(sdata), int'(w0[0]));
    repeat (3) next_tick();
    check(sdata == w0[0] && underrun == 1'b1, "R7 still holding", int'({sdata, underrun}), int'({w0[0], 1'b1}));
    put_word(w1);
    mm = 0;
    for (int t = 0; t < 32; t++) begin
      next_tick();
      if (sdata !== w1[31 - t]) mm++;
    end
    check(mm == 0, "R7 late word sent whole", mm, 0);
    next_tick();
    check(done == 1'b1 && sdata == 1'b0, "R6 done after count with stall", int'({done, sdata}), 2);
    check(underrun == 1'b1, "R7 underrun sticky", int'(underrun), 1);
    @(negedge clk) en = 1'b0;
    @(negedge clk);
    check(done == 1'b0 && underrun == 1'b0 && sdata == 1'b0, "R8 disable clears", int'({done, underrun, sdata}), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule